// File: doc/BRIEF.md
# Sample rate clock divider

This block turns a fast master clock into a one-cycle frame strobe at the audio sample rate. A 5-bit rate code together with a USB-mode bit selects an integer divide ratio. Normal mode uses ratios built on 128 and 192, and USB mode uses ratios such as 125, 250, 272 and 750 that suit a 12 MHz style master clock. An optional halving bit divides the master clock by two before the main division. For the selected entry the block also reports a two-bit filter class, which a decimation filter downstream uses to choose its response.

When the device is a clock slave, an autodetect unit measures how many master-clock cycles fall between rising edges of an externally supplied frame clock. It accepts a new ratio only after two consecutive frames give the same count, and it reports that ratio as a 3-bit code. A rate code that is not listed for the current mode raises a flag. The divider then keeps the last valid ratio.

Top module: `srdiv_top`

## Requirements
- R1: In normal mode (usb_mode=0, mclk_half=0) the strobe period in clock cycles is: 00000→256, 00001→384, 01010→768, 01011→1152, 01100→384, 01101→576, 01110→128, 01111→192, 10000→256, 10001→384, 11010→512, 11011→768, 11100→512, 11101→768, 11110→128, 11111→192.
- R2: In USB mode (usb_mode=1, mclk_half=0) the strobe period is: 00000→250, 01010→750, 01100→375, 01110→125, 10001→272, 11011→544, 11100→500, 11111→136.
- R3: With mclk_half=1 the strobe period is twice the ratio selected by the code and mode.
- R4: rate_stb is high for exactly one clock cycle per period, including for odd ratios.
- R5: filt_class (A=0, B=1, C=2, D=3) is B for ratios 128, 192 and for the USB ratio 136. It is C for the USB ratios 250, 375, 500 and 750, D for the USB ratio 125, and A otherwise.
- R6: A code that is not listed for the current mode sets code_bad one cycle later, and the period and class of the last valid entry are kept. A listed code clears code_bad again.
- R7: After reset rate_stb=0, code_bad=0, det_locked=0, det_code=0, filt_class=A, and the held ratio is 256.
- R8: With slave_mode=1 and mclk_half=0, frame periods of 128, 192, 256 and 384 cycles give det_code 0, 1, 2 and 3.
- R9: With slave_mode=1 and mclk_half=1, frame periods of 256, 384, 512, 768, 1024 and 1536 cycles give det_code 2, 3, 4, 5, 6 and 7. A period of 128 is not accepted in this mode.
- R10: det_code and det_locked change only on a frame rising edge where the last two measured periods are equal and recognised. An unrecognised period, or periods that alternate, leave them unchanged.
- R11: With slave_mode=0, det_code and det_locked do not change, whatever frame_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_code | input | 5 | Sample-rate code |
| usb_mode | input | 1 | 1 selects the USB ratio table |
| mclk_half | input | 1 | 1 pre-divides the master clock by two |
| slave_mode | input | 1 | 1 enables frame-clock autodetect |
| frame_in | input | 1 | External frame clock, synchronous to clk |
| rate_stb | output | 1 | One-cycle sample-rate strobe |
| filt_class | output | 2 | Filter class of the held entry (A=0, B=1, C=2, D=3) |
| code_bad | output | 1 | Current code is not listed for the mode |
| det_code | output | 3 | Autodetected ratio code |
| det_locked | output | 1 | At least one ratio has been detected |

## Verification
A configuration change reaches the held ratio, the class and code_bad one cycle later. The strobe counter then settles within at most one old period. The bench therefore checks code_bad two cycles after a change, and it measures a period only after two strobes have gone by, counting the cycles between two consecutive strobes. The detected code updates on the cycle after the third rising edge of a steady frame clock, so every autodetect check is made only after four complete frames.

// File: rtl/srdiv_pkg.sv
package srdiv_pkg;
    localparam int RATIO_W = 11;
    localparam int CNT_W   = 12;

    typedef enum logic [1:0] {FC_A = 2'd0, FC_B = 2'd1, FC_C = 2'd2, FC_D = 2'd3} fclass_e;

    typedef struct packed {
        logic               ok;
        logic [RATIO_W-1:0] ratio;
        fclass_e            cls;
    } rate_ent_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] code;
    } det_ent_t;

    function automatic rate_ent_t mk(input int r, input fclass_e c);
        rate_ent_t e;
        e.ok    = 1'b1;
        e.ratio = RATIO_W'(r);
        e.cls   = c;
        return e;
    endfunction

    function automatic rate_ent_t lookup(input logic usb, input logic [4:0] code);
        rate_ent_t e;
        e = '{ok: 1'b0, ratio: '0, cls: FC_A};
        if (!usb) begin
            case (code)
                5'b00000, 5'b10000: e = mk(256, FC_A);
                5'b00001, 5'b01100,
                5'b10001:           e = mk(384, FC_A);
                5'b01010, 5'b11011,
                5'b11101:           e = mk(768, FC_A);
                5'b01011:           e = mk(1152, FC_A);
                5'b01101:           e = mk(576, FC_A);
                5'b01110, 5'b11110: e = mk(128, FC_B);
                5'b01111, 5'b11111: e = mk(192, FC_B);
                5'b11010, 5'b11100: e = mk(512, FC_A);
                default:            e.ok = 1'b0;
            endcase
        end else begin
            case (code)
                5'b00000: e = mk(250, FC_C);
                5'b01010: e = mk(750, FC_C);
                5'b01100: e = mk(375, FC_C);
                5'b01110: e = mk(125, FC_D);
                5'b10001: e = mk(272, FC_A);
                5'b11011: e = mk(544, FC_A);
                5'b11100: e = mk(500, FC_C);
                5'b11111: e = mk(136, FC_B);
                default:  e.ok = 1'b0;
            endcase
        end
        return e;
    endfunction

    function automatic det_ent_t classify(input logic half, input logic [CNT_W-1:0] n);
        det_ent_t d;
        d = '{ok: 1'b1, code: 3'd0};
        case (n)
            CNT_W'(128):  d.code = 3'd0;
            CNT_W'(192):  d.code = 3'd1;
            CNT_W'(256):  d.code = 3'd2;
            CNT_W'(384):  d.code = 3'd3;
            CNT_W'(512):  d.code = 3'd4;
            CNT_W'(768):  d.code = 3'd5;
            CNT_W'(1024): d.code = 3'd6;
            CNT_W'(1536): d.code = 3'd7;
            default:      d.ok   = 1'b0;
        endcase
        if (d.ok && !half && d.code > 3'd3) d.ok = 1'b0;
        if (d.ok &&  half && d.code < 3'd2) d.ok = 1'b0;
        return d;
    endfunction
endpackage

// File: rtl/srdiv_ratio_sel.sv
module srdiv_ratio_sel
    import srdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         sr_code,
    input  logic               usb_mode,
    output logic [RATIO_W-1:0] ratio,
    output fclass_e            cls,
    output logic               bad
);
    rate_ent_t ent;
    assign ent = lookup(usb_mode, sr_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio <= RATIO_W'(256);
            cls   <= FC_A;
            bad   <= 1'b0;
        end else if (ent.ok) begin
            ratio <= ent.ratio;
            cls   <= ent.cls;
            bad   <= 1'b0;
        end else begin
            bad   <= 1'b1;
        end
    end

    AST_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (rst)
        !ent.ok |=> (ratio == $past(ratio) && cls == $past(cls))); // R6
    AST_RATIO_SPAN: assert property (@(posedge clk) disable iff (rst)
        ent.ok |=> (ratio >= RATIO_W'(125) && ratio <= RATIO_W'(1152))); // R1
    AST_CLASS_D_USB: assert property (@(posedge clk) disable iff (rst)
        (cls == FC_D) |-> (ratio == RATIO_W'(125))); // R5
endmodule

// File: rtl/srdiv_counter.sv
module srdiv_counter
    import srdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               half,
    input  logic [RATIO_W-1:0] ratio,
    output logic               stb
);
    logic               pre;
    logic               tick;
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] last;

    assign tick = !half || pre;
    assign last = ratio - RATIO_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= 1'b0;
            cnt <= '0;
            stb <= 1'b0;
        end else begin
            pre <= half ? !pre : 1'b0;
            stb <= 1'b0;
            if (tick) begin
                if (cnt >= last) begin
                    cnt <= '0;
                    stb <= 1'b1;
                end else begin
                    cnt <= cnt + RATIO_W'(1);
                end
            end
        end
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb); // R4
    AST_HALF_GAP: assert property (@(posedge clk) disable iff (rst)
        (half && $past(half) && stb) |=> !stb); // R3
endmodule

// File: rtl/srdiv_autodet.sv
module srdiv_autodet
    import srdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       half,
    input  logic       frame_in,
    output logic [2:0] code,
    output logic       locked
);
    logic             frame_q;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] prev;
    logic [1:0]       seen;
    det_ent_t         cur;

    assign rise = en && frame_in && !frame_q;
    assign cur  = classify(half, cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
            cnt     <= '0;
            prev    <= '0;
            seen    <= '0;
            code    <= '0;
            locked  <= 1'b0;
        end else begin
            frame_q <= frame_in;
            if (!en) begin
                seen <= '0;
                cnt  <= '0;
            end else if (rise) begin
                cnt  <= CNT_W'(1);
                prev <= cnt;
                if (seen != 2'd2) seen <= seen + 2'd1;
                if (seen == 2'd2 && cnt == prev && cur.ok) begin
                    code   <= cur.code;
                    locked <= 1'b1;
                end
            end else if (cnt != {CNT_W{1'b1}}) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_DET_SLAVE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(code) && $stable(locked))); // R11
    AST_DET_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (code != $past(code)) |-> $past(rise)); // R10
    AST_DET_HALF_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (rise && half) |=> (code == $past(code) || code >= 3'd2)); // R9
endmodule

// File: rtl/srdiv_top.sv
module srdiv_top
    import srdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] sr_code,
    input  logic       usb_mode,
    input  logic       mclk_half,
    input  logic       slave_mode,
    input  logic       frame_in,
    output logic       rate_stb,
    output logic [1:0] filt_class,
    output logic       code_bad,
    output logic [2:0] det_code,
    output logic       det_locked
);
    logic [RATIO_W-1:0] ratio;
    fclass_e            cls;

    srdiv_ratio_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .sr_code  (sr_code),
        .usb_mode (usb_mode),
        .ratio    (ratio),
        .cls      (cls),
        .bad      (code_bad)
    );

    srdiv_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .half  (mclk_half),
        .ratio (ratio),
        .stb   (rate_stb)
    );

    srdiv_autodet u_det (
        .clk      (clk),
        .rst      (rst),
        .en       (slave_mode),
        .half     (mclk_half),
        .frame_in (frame_in),
        .code     (det_code),
        .locked   (det_locked)
    );

    assign filt_class = cls;
endmodule

// File: tb/tb_srdiv_top.sv
module tb_srdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sr_code = 5'b00000;
    logic       usb_mode = 1'b0;
    logic       mclk_half = 1'b0;
    logic       slave_mode = 1'b0;
    logic       frame_in = 1'b0;
    logic       rate_stb;
    logic [1:0] filt_class;
    logic       code_bad;
    logic [2:0] det_code;
    logic       det_locked;

    int n_chk = 0;
    int n_err = 0;
    bit hung  = 1'b0;

    always #4 clk = ~clk;

    srdiv_top dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_stb();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!rate_stb && k < 10000);
        if (!rate_stb) hung = 1'b1;
    endtask

    task automatic measure(output int per, output int wid_ok);
        int k = 0;
        wait_stb();
        wait_stb();
        @(negedge clk);
        wid_ok = rate_stb ? 0 : 1;
        k = 1;
        while (!rate_stb && k < 10000) begin
            @(negedge clk);
            k++;
        end
        per = k;
    endtask

    task automatic t_rate(input string tag, input logic usb, input logic [4:0] c,
                          input logic h, input int exp_per, input int exp_cls);
        int per, w;
        @(negedge clk);
        usb_mode = usb; sr_code = c; mclk_half = h;
        measure(per, w);
        check({tag, " period"}, per, exp_per);
        check("R4 width", w, 1);
        check({"R5 class ", tag}, filt_class, exp_cls);
    endtask

    task automatic t_reset();
        int per, w;
        @(negedge clk);
        check("R7 stb", rate_stb, 0);
        check("R7 bad", code_bad, 0);
        check("R7 locked", det_locked, 0);
        check("R7 detcode", det_code, 0);
        check("R7 class", filt_class, 0);
        measure(per, w);
        check("R7 period", per, 256);
    endtask

    task automatic t_bad();
        int per, w;
        t_rate("R2", 1'b1, 5'b01100, 1'b0, 375, 2);
        @(negedge clk);
        sr_code = 5'b00001;
        @(negedge clk);
        @(negedge clk);
        check("R6 flag set", code_bad, 1);
        measure(per, w);
        check("R6 held period", per, 375);
        check("R6 held class", filt_class, 2);
        usb_mode = 1'b0; sr_code = 5'b00010;
        measure(per, w);
        check("R6 normal unlisted period", per, 375);
        check("R6 normal unlisted flag", code_bad, 1);
        sr_code = 5'b01111;
        @(negedge clk);
        @(negedge clk);
        check("R6 flag clear", code_bad, 0);
    endtask

    task automatic frames(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            frame_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            frame_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic t_det(input string tag, input logic h, input int p,
                         input int exp_code, input int exp_lock);
        @(negedge clk);
        mclk_half = h;
        frames(p, 5);
        check({tag, " detcode"}, det_code, exp_code);
        check({tag, " locked"}, det_locked, exp_lock);
    endtask

    task automatic t_alternate();
        @(negedge clk);
        slave_mode = 1'b1; mclk_half = 1'b0;
        for (int i = 0; i < 4; i++) begin
            frames(256, 1);
            frames(384, 1);
        end
        check("R10 alternating locked", det_locked, 0);
        check("R10 alternating code", det_code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rate("R1 00000", 1'b0, 5'b00000, 1'b0, 256, 0);
        t_rate("R1 01011", 1'b0, 5'b01011, 1'b0, 1152, 0);
        t_rate("R1 01101", 1'b0, 5'b01101, 1'b0, 576, 0);
        t_rate("R1 01110", 1'b0, 5'b01110, 1'b0, 128, 1);
        t_rate("R1 11111", 1'b0, 5'b11111, 1'b0, 192, 1);
        t_rate("R1 11010", 1'b0, 5'b11010, 1'b0, 512, 0);
        t_rate("R1 11101", 1'b0, 5'b11101, 1'b0, 768, 0);
        t_rate("R2 01110", 1'b1, 5'b01110, 1'b0, 125, 3);
        t_rate("R2 01100", 1'b1, 5'b01100, 1'b0, 375, 2);
        t_rate("R2 01010", 1'b1, 5'b01010, 1'b0, 750, 2);
        t_rate("R2 10001", 1'b1, 5'b10001, 1'b0, 272, 0);
        t_rate("R2 11111", 1'b1, 5'b11111, 1'b0, 136, 1);
        t_rate("R2 11011", 1'b1, 5'b11011, 1'b0, 544, 0);
        t_rate("R3 usb 125", 1'b1, 5'b01110, 1'b1, 250, 3);
        t_rate("R3 normal 384", 1'b0, 5'b00001, 1'b1, 768, 0);
        mclk_half = 1'b0;
        t_bad();
        t_alternate();
        t_det("R8 128", 1'b0, 128, 0, 1);
        t_det("R8 384", 1'b0, 384, 3, 1);
        t_det("R8 192", 1'b0, 192, 1, 1);
        t_det("R9 1536", 1'b1, 1536, 7, 1);
        t_det("R9 512", 1'b1, 512, 4, 1);
        t_det("R9 128 rejected", 1'b1, 128, 4, 1);
        t_det("R10 300 unrecognised", 1'b0, 300, 4, 1);
        @(negedge clk);
        slave_mode = 1'b0;
        t_det("R11 slave off", 1'b0, 256, 4, 1);
        if (hung) check("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule